// File: doc/BRIEF.md
# Queued SPI Master Sequencer

This block is an SPI bus master that works through a list of up to sixteen prepared transfers on its own. The host fills a transmit queue through a plain write port. Each entry holds a data word, a word-length code that selects 8 to 16 bits, and the chip-select pattern for that entry. The host then sets the clock polarity and phase, the clock divider and the index of the last entry, and pulses `start`. From that point the sequencer produces the serial clock, drives `mosi` most significant bit first and samples `miso`. It needs no further action from the host until the whole queue has been sent.

Each received word goes into a receive buffer at the index of the entry that produced it. The host reads the buffer through a registered read port once `done` has pulsed. A frame for an entry starts with one idle half-period with chip-select already asserted. The clock edges follow, then one more idle half-period. Chip-select stays asserted into the next entry when that entry uses the same pattern. When the pattern changes, the bus goes idle for one full clock period between the two entries.

Top module: `spi_queue_master`

## Requirements
- R1: The word length of an entry is its 4-bit length code plus one, and a code below 7 gives 8 bits. Only the low bits of the data word that fall inside this length are sent, most significant first.
- R2: After a `start` pulse accepted while idle, entries 0 up to `cfg_last` are sent in index order with no further input. A `start` pulse while busy is ignored.
- R3: While an entry is active, `cs_n[j]` is low exactly when bit j of that entry's chip-select pattern is 1. While idle, all `cs_n` bits are high.
- R4: Between two consecutive entries whose patterns differ, all `cs_n` are high for two half-periods. Between entries with equal patterns, `cs_n` stays unchanged.
- R5: Every half-period lasts `cfg_div`+1 clocks. While idle, `sclk` equals `cfg_cpol`, delayed by one register. Each entry frame is one idle-level half-period, then 2×length clocking half-periods, then one idle-level half-period.
- R6: With `cfg_cpha`=0, the first bit is on `mosi` from the start of the frame, `mosi` changes on trailing edges and `miso` is sampled on leading edges. With `cfg_cpha`=1, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R7: The word received for entry i is stored at receive index i, right-aligned with zeros above its length. It appears on `rx_rdata` one clock after `rx_raddr` is presented.
- R8: `busy` rises on the clock edge that accepts `start` and falls on the edge that ends the last entry. On that same edge `done` goes high for exactly one clock.
- R9: While reset is held, `sclk`, `mosi`, `busy` and `done` are 0 and all `cs_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| q_we | input | 1 | Write one transmit queue entry |
| q_waddr | input | 4 | Index of the entry written |
| q_wdata | input | 16 | Data word of the entry, right-aligned |
| q_wlen | input | 4 | Word-length code (length minus one) |
| q_wcs | input | 4 | Chip-select pattern, 1 selects |
| cfg_cpol | input | 1 | Idle level of sclk |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_div | input | 8 | Half-period minus one, in clocks |
| cfg_last | input | 4 | Index of the last entry to send |
| start | input | 1 | Begin running the queue |
| rx_raddr | input | 4 | Receive buffer read index |
| rx_rdata | output | 16 | Receive buffer data, one clock after address |
| miso | input | 1 | Serial data from the slaves |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slaves |
| cs_n | output | 4 | Chip-select lines, active low |
| busy | output | 1 | Queue run in progress |
| done | output | 1 | One-clock pulse when the queue finishes |

## Verification
The queue is run with all four polarity and phase settings and with dividers of 0, 1 and 2. One run covers every length code from 0 to 15. This tells apart correct edge choice, half-period counting and length clamping from an error in any one of them. Chip-select patterns are grouped so that some neighbouring entries share a pattern and others differ, which shows whether the idle gap appears only on a change. `miso` carries a pseudo-random bit stream that changes every clock, so a sample taken one edge early or late gives a different received word. A second `start` during a run checks that the running queue is undisturbed.

// File: rtl/spq_pkg.sv
package spq_pkg;
  localparam int DATA_W = 16;
  localparam int LEN_W  = 4;
  localparam int HALF_W = $clog2(2 * DATA_W + 3);

  function automatic logic [4:0] word_bits(input logic [LEN_W-1:0] code);
    if (code < 4'd7) return 5'd8;
    return {1'b0, code} + 5'd1;
  endfunction
endpackage

// File: rtl/spq_ram.sv
module spq_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spq_divider.sv
module spq_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] div,
  input  logic             run,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      div_q <= '0;
    end else if (load) begin
      cnt   <= div;
      div_q <= div;
    end else if (run) begin
      cnt <= (cnt == '0) ? div_q : cnt - 1'b1;
    end
  end

  assign tick = run && (cnt == '0);

  p_cnt_range_r5: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= div_q));
endmodule

// File: rtl/spq_engine.sv
module spq_engine
  import spq_pkg::*;
#(
  parameter int NCS   = 4,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [IDX_W-1:0]  cfg_last,
  input  logic              tick,
  input  logic              miso,
  input  logic [DATA_W-1:0] nxt_data,
  input  logic [LEN_W-1:0]  nxt_len,
  input  logic [NCS-1:0]    nxt_cs,
  output logic [IDX_W-1:0]  rd_ptr,
  output logic              accept,
  output logic              run,
  output logic              rx_we,
  output logic [IDX_W-1:0]  rx_widx,
  output logic [DATA_W-1:0] rx_wdata,
  output logic              sclk,
  output logic              mosi,
  output logic [NCS-1:0]    cs_n,
  output logic              busy,
  output logic              done
);
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  lat_last;
  logic              lat_cpol, lat_cpha;
  logic [HALF_W-1:0] half;
  logic              gap, gcnt;
  logic [DATA_W-1:0] cur_data;
  logic [4:0]        cur_bits;
  logic [NCS-1:0]    cur_cs;
  logic [DATA_W-1:0] rx_sh;

  logic [4:0]        nxt_bits, nxt_top;
  logic [HALF_W-1:0] half_nx, two_l, end_half, s_lo, s_hi, b_raw;
  logic [4:0]        b_idx, bit_pos;
  logic              sample_now, clk_active, entry_end, gap_done, is_last, do_load;

  always_comb begin
    nxt_bits   = word_bits(nxt_len);
    nxt_top    = nxt_bits - 5'd1;
    half_nx    = half + HALF_W'(1);
    two_l      = HALF_W'({cur_bits, 1'b0});
    end_half   = two_l + HALF_W'(2);
    s_lo       = HALF_W'(1) + HALF_W'(lat_cpha);
    s_hi       = two_l - HALF_W'(1) + HALF_W'(lat_cpha);
    sample_now = run && tick && !gap && (half_nx >= s_lo) && (half_nx <= s_hi)
                 && (half_nx[0] != lat_cpha);
    clk_active = (half_nx >= HALF_W'(1)) && (half_nx <= two_l) && half_nx[0];
    b_raw      = lat_cpha ? ((half_nx - HALF_W'(1)) >> 1) : (half_nx >> 1);
    b_idx      = (b_raw >= HALF_W'(cur_bits)) ? (cur_bits - 5'd1) : b_raw[4:0];
    bit_pos    = cur_bits - 5'd1 - b_idx;
    accept     = !run && start;
    is_last    = (idx == lat_last);
    entry_end  = run && tick && !gap && (half_nx == end_half);
    gap_done   = run && tick && gap && gcnt;
    do_load    = accept || gap_done || (entry_end && !is_last && (nxt_cs == cur_cs));
    rd_ptr     = run ? idx + IDX_W'(1) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      cs_n     <= '1;
      idx      <= '0;
      lat_last <= '0;
      lat_cpol <= 1'b0;
      lat_cpha <= 1'b0;
      half     <= '0;
      gap      <= 1'b0;
      gcnt     <= 1'b0;
      cur_data <= '0;
      cur_bits <= 5'd8;
      cur_cs   <= '0;
      rx_sh    <= '0;
      rx_we    <= 1'b0;
      rx_widx  <= '0;
      rx_wdata <= '0;
    end else begin
      done  <= 1'b0;
      rx_we <= 1'b0;
      if (accept) begin
        run      <= 1'b1;
        busy     <= 1'b1;
        lat_cpol <= cfg_cpol;
        lat_cpha <= cfg_cpha;
        lat_last <= cfg_last;
      end
      if (!run && !accept) sclk <= cfg_cpol;
      if (entry_end) begin
        rx_we    <= 1'b1;
        rx_widx  <= idx;
        rx_wdata <= rx_sh;
      end
      if (do_load) begin
        idx      <= run ? idx + IDX_W'(1) : '0;
        cur_data <= nxt_data;
        cur_bits <= nxt_bits;
        cur_cs   <= nxt_cs;
        half     <= '0;
        gap      <= 1'b0;
        gcnt     <= 1'b0;
        rx_sh    <= '0;
        cs_n     <= ~nxt_cs;
        sclk     <= run ? lat_cpol : cfg_cpol;
        mosi     <= nxt_data[nxt_top[3:0]];
      end else if (run && tick) begin
        if (gap) begin
          gcnt <= 1'b1;
        end else begin
          half <= half_nx;
          if (sample_now) rx_sh <= {rx_sh[DATA_W-2:0], miso};
          if (entry_end) begin
            sclk <= lat_cpol;
            cs_n <= '1;
            if (is_last) begin
              run  <= 1'b0;
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              gap  <= 1'b1;
              gcnt <= 1'b0;
            end
          end else begin
            sclk <= lat_cpol ^ clk_active;
            mosi <= cur_data[bit_pos[3:0]];
          end
        end
      end
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_busy_done_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  p_idle_cs_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (&cs_n));
  p_no_clock_in_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && (sclk != $past(sclk))) |-> !gap);
  p_half_bound_r1: assert property (@(posedge clk) disable iff (rst)
    (run && !gap) |-> (half < end_half));
endmodule

// File: rtl/spi_queue_master.sv
module spi_queue_master
  import spq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NCS   = 4,
  parameter int DIV_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ENT_W = NCS + LEN_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              q_we,
  input  logic [IDX_W-1:0]  q_waddr,
  input  logic [DATA_W-1:0] q_wdata,
  input  logic [LEN_W-1:0]  q_wlen,
  input  logic [NCS-1:0]    q_wcs,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [IDX_W-1:0]  cfg_last,
  input  logic              start,
  input  logic [IDX_W-1:0]  rx_raddr,
  output logic [DATA_W-1:0] rx_rdata,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [NCS-1:0]    cs_n,
  output logic              busy,
  output logic              done
);
  logic [ENT_W-1:0]  ent_q;
  logic [IDX_W-1:0]  rd_ptr;
  logic              accept, run, tick;
  logic              rx_we;
  logic [IDX_W-1:0]  rx_widx;
  logic [DATA_W-1:0] rx_wdata;

  spq_ram #(.W(ENT_W), .DEPTH(DEPTH), .AW(IDX_W)) u_txq (
    .clk(clk), .we(q_we), .waddr(q_waddr),
    .wdata({q_wcs, q_wlen, q_wdata}),
    .raddr(rd_ptr), .rdata(ent_q)
  );

  spq_ram #(.W(DATA_W), .DEPTH(DEPTH), .AW(IDX_W)) u_rxq (
    .clk(clk), .we(rx_we), .waddr(rx_widx), .wdata(rx_wdata),
    .raddr(rx_raddr), .rdata(rx_rdata)
  );

  spq_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .load(accept), .div(cfg_div), .run(run), .tick(tick)
  );

  spq_engine #(.NCS(NCS), .IDX_W(IDX_W)) u_eng (
    .clk(clk), .rst(rst), .start(start),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_last(cfg_last),
    .tick(tick), .miso(miso),
    .nxt_data(ent_q[DATA_W-1:0]),
    .nxt_len(ent_q[DATA_W +: LEN_W]),
    .nxt_cs(ent_q[DATA_W+LEN_W +: NCS]),
    .rd_ptr(rd_ptr), .accept(accept), .run(run),
    .rx_we(rx_we), .rx_widx(rx_widx), .rx_wdata(rx_wdata),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy), .done(done)
  );
endmodule

// File: tb/tb_spi_queue_master.sv
module tb_spi_queue_master;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst;
  logic        q_we;
  logic [3:0]  q_waddr, q_wlen, q_wcs;
  logic [15:0] q_wdata;
  logic        cfg_cpol, cfg_cpha;
  logic [7:0]  cfg_div;
  logic [3:0]  cfg_last, rx_raddr;
  logic        start;
  logic [15:0] rx_rdata;
  logic        miso, sclk, mosi, busy, done;
  logic [3:0]  cs_n;

  spi_queue_master dut (
    .clk(clk), .rst(rst), .q_we(q_we), .q_waddr(q_waddr), .q_wdata(q_wdata),
    .q_wlen(q_wlen), .q_wcs(q_wcs), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_div(cfg_div), .cfg_last(cfg_last), .start(start), .rx_raddr(rx_raddr),
    .rx_rdata(rx_rdata), .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign miso = lfsr[0];

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  bit cmp_on = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // bench copy of the queue contents
  logic [15:0] t_data [16];
  logic [3:0]  t_len  [16];
  logic [3:0]  t_cs   [16];
  logic [15:0] m_rx   [16];

  // reference model state
  int   m_run = 0, m_i, m_h, m_gap, m_g, m_cnt, m_L, m_last, m_div;
  bit   m_cpol, m_cpha, m_mosi_ok = 0;
  logic [15:0] m_word;
  logic exp_sclk = 0, exp_mosi = 0, exp_busy = 0, exp_done = 0;
  logic [3:0] exp_cs_n = 4'hF;

  function automatic int len_of(input logic [3:0] c);
    return (c < 7) ? 8 : int'(c) + 1;
  endfunction

  task m_start_entry;
    m_h = 0; m_L = len_of(t_len[m_i]); m_word = 16'h0;
  endtask

  task m_set_out;
    int b;
    if (m_gap != 0) begin
      exp_cs_n = 4'hF; exp_sclk = m_cpol; m_mosi_ok = 0;
    end else begin
      exp_cs_n = ~t_cs[m_i];
      exp_sclk = m_cpol ^ ((m_h >= 1 && m_h <= 2*m_L && (m_h % 2) == 1) ? 1'b1 : 1'b0);
      b = m_cpha ? ((m_h == 0) ? 0 : (m_h - 1) / 2) : m_h / 2;
      if (b > m_L - 1) b = m_L - 1;
      exp_mosi = t_data[m_i][m_L - 1 - b];
      m_mosi_ok = 1;
    end
  endtask

  task m_advance;
    int s;
    if (m_gap != 0) begin
      m_g++;
      if (m_g == 2) begin m_gap = 0; m_start_entry(); end
      m_set_out();
    end else begin
      m_h++;
      s = m_h - 1 - int'(m_cpha);
      if (s >= 0 && (s % 2) == 0 && s / 2 < m_L) m_word = {m_word[14:0], miso};
      if (m_h == 2*m_L + 2) begin
        m_rx[m_i] = m_word;
        if (m_i == m_last) begin
          m_run = 0; exp_done = 1; exp_busy = 0; exp_cs_n = 4'hF;
          exp_sclk = m_cpol; m_mosi_ok = 0;
        end else begin
          m_i++;
          if (t_cs[m_i] != t_cs[m_i-1]) begin m_gap = 1; m_g = 0; end
          else m_start_entry();
          m_set_out();
        end
      end else m_set_out();
    end
  endtask

  always @(posedge clk) begin
    exp_done = 0;
    if (rst) begin
      m_run = 0; exp_sclk = 0; exp_mosi = 0; exp_cs_n = 4'hF; exp_busy = 0; m_mosi_ok = 0;
    end else if (m_run == 0) begin
      if (start) begin
        m_cpol = cfg_cpol; m_cpha = cfg_cpha; m_div = int'(cfg_div); m_last = int'(cfg_last);
        m_run = 1; m_i = 0; m_gap = 0; m_cnt = m_div; exp_busy = 1;
        m_start_entry(); m_set_out();
      end else begin
        exp_sclk = cfg_cpol; exp_cs_n = 4'hF; m_mosi_ok = 0;
      end
    end else begin
      if (m_cnt > 0) m_cnt--;
      else begin m_cnt = m_div; m_advance(); end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check("R5", "sclk", int'(sclk), int'(exp_sclk));
      check("R3 R4", "cs_n", int'(cs_n), int'(exp_cs_n));
      check("R2 R8", "busy", int'(busy), int'(exp_busy));
      check("R8", "done", int'(done), int'(exp_done));
      if (m_mosi_ok) check("R1 R6", "mosi", int'(mosi), int'(exp_mosi));
    end
  end

  task automatic write_entry(input int i, input logic [15:0] d, input logic [3:0] l, input logic [3:0] c);
    @(negedge clk);
    q_we = 1; q_waddr = 4'(i); q_wdata = d; q_wlen = l; q_wcs = c;
    t_data[i] = d; t_len[i] = l; t_cs[i] = c;
    @(negedge clk);
    q_we = 0;
  endtask

  task automatic run_queue(input bit pol, input bit pha, input int dv, input int last, input bit restart);
    @(negedge clk);
    cfg_cpol = pol; cfg_cpha = pha; cfg_div = 8'(dv); cfg_last = 4'(last);
    repeat (3) @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    if (restart) begin
      repeat (20) @(negedge clk);
      start = 1;   // R2: must be ignored while busy
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    for (int i = 0; i <= last; i++) begin
      rx_raddr = 4'(i);
      @(negedge clk);
      @(negedge clk);
      check("R7", $sformatf("rx[%0d]", i), int'(rx_rdata), int'(m_rx[i]));
    end
  endtask

  initial begin
    rst = 1; q_we = 0; q_waddr = 0; q_wdata = 0; q_wlen = 0; q_wcs = 0;
    cfg_cpol = 0; cfg_cpha = 0; cfg_div = 0; cfg_last = 0; start = 0; rx_raddr = 0;
    repeat (3) @(negedge clk);
    check("R9", "reset sclk", int'(sclk), 0);
    check("R9", "reset mosi", int'(mosi), 0);
    check("R9", "reset cs_n", int'(cs_n), 15);
    check("R9", "reset busy", int'(busy), 0);
    check("R9", "reset done", int'(done), 0);
    rst = 0;
    cmp_on = 1;

    // Run A: mode 0, fastest clock, length clamp, shared then changed select
    write_entry(0, 16'h00A5, 4'd7,  4'b0001);
    write_entry(1, 16'hFF3C, 4'd3,  4'b0001);
    write_entry(2, 16'hBEEF, 4'd15, 4'b0010);
    run_queue(0, 0, 0, 2, 0);

    // Run B: mode 3, divider 2, all sixteen entries and every length code
    for (int i = 0; i < 16; i++)
      write_entry(i, 16'(i * 16'h1357) ^ 16'hA5C3, 4'(i), 4'(1 << ((i / 3) % 4)));
    run_queue(1, 1, 2, 15, 0);

    // Run C: mode 1, divider 1, single 12-bit entry, extra start mid-run
    write_entry(0, 16'h0ABC, 4'd11, 4'b1000);
    run_queue(0, 1, 1, 0, 1);

    // Run D: mode 2, divider 0, two entries with different selects
    write_entry(0, 16'h5A5A, 4'd9,  4'b0101);
    write_entry(1, 16'h1234, 4'd12, 4'b0110);
    run_queue(1, 0, 0, 1, 0);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R2 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule